// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Prescaler and Selectable Stop

This block produces one pulse-width-modulated output. A prescaler divides the module clock into a slower PWM tick, and a period counter advances by one on each tick. In each period the output is high for a programmed number of ticks and low for the rest. Two cases are handled apart from that rule. A force flag holds the output high for the whole period. A duty count of zero keeps the output low with no pulses.

Three words are written through a simple register port. The control word holds the prescale divisor and the stop method. The duty word holds the duty count and the force flag. The period word holds the period length in ticks. The clock-enable input starts and stops the channel. On a stop the output goes low either on the next clock or after the current period ends, as the stop-method bit selects. Duty and period values written while the channel runs wait in shadow copies and take effect at the next period boundary.

The sequencer is a three-state machine:
- **ST_IDLE**: counters cleared and output low.
- **ST_RUN**: normal operation.
- **ST_DRAIN**: a graceful stop is finishing the current period.

Its transitions are:
- **START** (ST_IDLE to ST_RUN): the clock enable is high.
- **HARD_STOP** (ST_RUN to ST_IDLE): the enable is low and the abrupt method is selected, or the graceful method is selected and the current period is ending in that cycle.
- **SOFT_STOP** (ST_RUN to ST_DRAIN): the enable is low, the graceful method is selected, and the period is not ending in that cycle.
- **DRAIN_DONE** (ST_DRAIN to ST_IDLE): the period ends.

Top module: `pwm_chan`

## Requirements
- R1: With prescale value P, a PWM tick occurs once every P+1 module clocks while the channel runs, so P=0 gives a tick on every clock. The divisor is taken directly from the control word.
- R2: Address 0 is the control word: prescale divisor in bits 5:0, stop method in bit 6. Bits 31:7 read as zero. All three words read as zero after reset.
- R3: With the force flag clear, period value L (0 behaves as 1) and duty count D, in running cycle c (c=0 is the first cycle after START) the output is high exactly when floor(c/(P+1)) mod L < D.
- R4: With the force flag clear and D=0, the output stays low for every cycle of the run.
- R5: With the force flag set, the output is high in every running cycle, whatever the duty count.
- R6: A duty count greater than or equal to the period value gives an output that is high in every running cycle.
- R7: Stop-method bit 0 selects a graceful stop. When the enable falls, the waveform continues to the end of the current period, and the output is low from the cycle after the final tick. The enable input is ignored while draining.
- R8: Stop-method bit 1 selects an abrupt stop. The output is low in the cycle after the clock edge that samples the enable low. In ST_IDLE the output is always low.
- R9: Duty and period values written while the channel runs leave the current period unchanged. They apply from the next period boundary.
- R10: When the enable is sampled high in ST_IDLE, the prescaler and period counter restart from zero. The output in the next cycle is the first cycle of a fresh period.
- R11: Address 1 is the duty word: duty count in bits CNT_W-1:0, force flag in bit 16. Address 2 is the period word in bits CNT_W-1:0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr (combinational) |
| clk_en | input | 1 | Channel enable; low requests a stop |
| pwm_out | output | 1 | PWM output |

## Verification
A register write lands at the clock edge where wr_en is high. Read data follows addr in the same cycle without a clock. An enable sampled at one edge changes the state for the cycle that follows. From then on, the output in running cycle c is given by the closed form in R3, because the prescaler and period counter are the only registers between the configuration and the output. The bench drives inputs one time unit after a rising edge and samples at the falling edge. Each expected value is computed from the cycle index counted from START, so every sample falls in the cycle the formula names. Mid-period writes and enable edges are placed in chosen cycles, so the point where a change must first appear is known exactly.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } pwm_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_DUTY   = 2'd1;
    localparam logic [1:0] ADDR_PERIOD = 2'd2;

    localparam int PRE_W     = 6;
    localparam int STOP_BIT  = 6;
    localparam int FORCE_BIT = 16;
endpackage

// File: rtl/pwm_regfile.sv
`timescale 1ns/1ps
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    output logic [PRE_W-1:0]   prescale,
    output logic               abrupt,
    output logic [CNT_W-1:0]   duty,
    output logic               force_hi,
    output logic [CNT_W-1:0]   period
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[31:FORCE_BIT+1], wr_data[FORCE_BIT-1:STOP_BIT+1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale <= '0;
            abrupt   <= 1'b0;
            duty     <= '0;
            force_hi <= 1'b0;
            period   <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_CTRL: begin
                    prescale <= wr_data[PRE_W-1:0];
                    abrupt   <= wr_data[STOP_BIT];
                end
                ADDR_DUTY: begin
                    duty     <= wr_data[CNT_W-1:0];
                    force_hi <= wr_data[FORCE_BIT];
                end
                ADDR_PERIOD: period <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_CTRL: begin
                rd_data[PRE_W-1:0] = prescale;
                rd_data[STOP_BIT]  = abrupt;
            end
            ADDR_DUTY: begin
                rd_data[CNT_W-1:0] = duty;
                rd_data[FORCE_BIT] = force_hi;
            end
            ADDR_PERIOD: rd_data[CNT_W-1:0] = period;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic [W-1:0] cnt,
    output logic         tick
);
    assign tick = run && (cnt >= div);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_period.sv
`timescale 1ns/1ps
module pwm_period #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] prog_duty,
    input  logic             prog_force,
    input  logic [CNT_W-1:0] prog_period,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_duty,
    output logic             act_force,
    output logic             wrap
);
    logic [CNT_W-1:0] act_period;
    logic [CNT_W-1:0] last;

    assign last = (act_period == '0) ? '0 : act_period - 1'b1;
    assign wrap = tick && (cnt >= last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            act_duty   <= '0;
            act_force  <= 1'b0;
            act_period <= '0;
        end else if (load || wrap) begin
            cnt        <= '0;
            act_duty   <= prog_duty;
            act_force  <= prog_force;
            act_period <= prog_period;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        clk_en,
    output logic        pwm_out
);
    pwm_state_e         state, state_nx;
    logic [PRE_W-1:0]   prescale;
    logic               abrupt;
    logic [CNT_W-1:0]   prog_duty;
    logic               prog_force;
    logic [CNT_W-1:0]   prog_period;
    logic [PRE_W-1:0]   pre_cnt;
    logic               tick;
    logic [CNT_W-1:0]   per_cnt;
    logic [CNT_W-1:0]   act_duty;
    logic               act_force;
    logic               wrap;
    logic               running;
    logic               start;

    assign running = (state != ST_IDLE);
    assign start   = (state == ST_IDLE) && clk_en;

    pwm_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data),
        .prescale(prescale), .abrupt(abrupt),
        .duty(prog_duty), .force_hi(prog_force), .period(prog_period)
    );

    pwm_prescaler #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(!running), .run(running),
        .div(prescale), .cnt(pre_cnt), .tick(tick)
    );

    pwm_period #(.CNT_W(CNT_W)) u_per (
        .clk(clk), .rst_n(rst_n), .load(start), .tick(tick),
        .prog_duty(prog_duty), .prog_force(prog_force), .prog_period(prog_period),
        .cnt(per_cnt), .act_duty(act_duty), .act_force(act_force), .wrap(wrap)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: START, HARD_STOP, SOFT_STOP, DRAIN_DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (clk_en) state_nx = ST_RUN;
            ST_RUN: begin
                if (!clk_en) begin
                    if (abrupt || wrap) state_nx = ST_IDLE;
                    else                state_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: if (wrap) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // output process
    always_comb begin
        pwm_out = 1'b0;
        unique case (state)
            ST_RUN, ST_DRAIN: pwm_out = act_force || (per_cnt < act_duty);
            default:          pwm_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_chan_sva.sv
`timescale 1ns/1ps
module pwm_chan_sva
    import pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             pwm_out,
    input pwm_state_e       state,
    input logic             abrupt,
    input logic             wrap,
    input logic             tick,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [CNT_W-1:0] per_cnt,
    input logic [CNT_W-1:0] act_duty,
    input logic             act_force
);
    p_tick_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_cnt == '0));

    p_zero_duty_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !act_force && act_duty == '0) |-> !pwm_out);

    p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && act_force) |-> pwm_out);

    p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !wrap) |=> (state == ST_DRAIN));

    p_drain_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && wrap) |=> (state == ST_IDLE && !pwm_out));

    p_abrupt_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !clk_en && abrupt) |=> (state == ST_IDLE));

    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !pwm_out);

    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !wrap) |=> ($stable(act_duty) && $stable(act_force)));

    p_fresh_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && clk_en) |=> (state == ST_RUN && pre_cnt == '0 && per_cnt == '0));
endmodule

bind pwm_chan pwm_chan_sva #(.CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pwm_out(pwm_out),
    .state(state), .abrupt(abrupt), .wrap(wrap), .tick(tick),
    .pre_cnt(pre_cnt), .per_cnt(per_cnt), .act_duty(act_duty), .act_force(act_force)
);

// File: tb/pwm_chan_test.sv
`timescale 1ns/1ps
module pwm_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        clk_en = 1'b0;
    logic        pwm_out;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_chan #(.CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .clk_en(clk_en), .pwm_out(pwm_out)
    );

    function automatic bit wave(int c, int p, int l, int d, bit f);
        int le = (l == 0) ? 1 : l;
        int pc = (c / (p + 1)) % le;
        return f || (pc < d);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pwm_out=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
        addr = a;
        #1;
        chk32(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        // R2 reset values
        @(negedge clk);
        rd_chk("R2 reset ctrl", 2'd0, 32'h0);
        rd_chk("R2 reset duty", 2'd1, 32'h0);
        rd_chk("R2 reset period", 2'd2, 32'h0);
        chk("R8 idle after reset", pwm_out, 1'b0);
        step();
        // R2 / R11 layout and reserved bits
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl reserved", 2'd0, 32'h0000_007F);
        wr(2'd1, 32'hFFFF_FFFF);
        rd_chk("R11 duty layout", 2'd1, 32'h0001_00FF);
        wr(2'd2, 32'hFFFF_FFFF);
        rd_chk("R11 period layout", 2'd2, 32'h0000_00FF);
        @(negedge clk);
        chk("R8 enable low keeps idle", pwm_out, 1'b0);
        step();

        // Sweep: R1 R3 R4 R5 R6 with abrupt stop R8 between runs
        for (int p = 0; p < 3; p++) begin
            for (int l = 0; l < 5; l++) begin
                for (int d = 0; d < 6; d++) begin
                    for (int f = 0; f < 2; f++) begin
                        int le = (l == 0) ? 1 : l;
                        int n  = 2 * le * (p + 1) + 2;
                        string tag;
                        if (f != 0)       tag = "R1 R5 force";
                        else if (d == 0)  tag = "R1 R4 zero duty";
                        else if (d >= le) tag = "R1 R6 full duty";
                        else              tag = "R1 R3 waveform";
                        wr(2'd0, 32'(64 | p));
                        wr(2'd1, 32'((f << 16) | d));
                        wr(2'd2, 32'(l));
                        clk_en = 1'b1;
                        step();
                        for (int c = 0; c < n; c++) begin
                            @(negedge clk);
                            chk($sformatf("%s P=%0d L=%0d D=%0d c=%0d", tag, p, l, d, c),
                                pwm_out, wave(c, p, l, d, f[0]));
                            step();
                        end
                        clk_en = 1'b0;
                        step();
                        @(negedge clk);
                        chk("R8 abrupt stop after sweep run", pwm_out, 1'b0);
                        step();
                    end
                end
            end
        end

        // R7 graceful stop, enable ignored while draining, then R10 restart
        wr(2'd0, 32'd1);
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd4);
        clk_en = 1'b1;
        step();
        for (int c = 0; c < 18; c++) begin
            bit e;
            if (c == 4) clk_en = 1'b0;
            if (c == 6) clk_en = 1'b1;
            @(negedge clk);
            if (c <= 7)      e = wave(c, 1, 4, 3, 1'b0);
            else if (c == 8) e = 1'b0;
            else             e = wave(c - 9, 1, 4, 3, 1'b0);
            chk($sformatf("%s c=%0d", (c <= 8) ? "R7 graceful" : "R10 restart", c), pwm_out, e);
            step();
        end
        clk_en = 1'b0;
        repeat (12) step();
        @(negedge clk);
        chk("R7 graceful stop reached idle", pwm_out, 1'b0);
        step();

        // R8 abrupt stop mid-period
        wr(2'd0, 32'd65);
        clk_en = 1'b1;
        step();
        for (int c = 0; c < 8; c++) begin
            if (c == 4) clk_en = 1'b0;
            @(negedge clk);
            chk($sformatf("R8 abrupt c=%0d", c), pwm_out,
                (c <= 4) ? wave(c, 1, 4, 3, 1'b0) : 1'b0);
            step();
        end

        // R9 shadowed duty update mid-period
        wr(2'd0, 32'd64);
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd4);
        clk_en = 1'b1;
        step();
        for (int c = 0; c < 12; c++) begin
            if (c == 1) begin wr_en = 1'b1; addr = 2'd1; wr_data = 32'd3; end
            if (c == 2) wr_en = 1'b0;
            @(negedge clk);
            chk($sformatf("R9 shadow c=%0d", c), pwm_out,
                (c < 4) ? wave(c, 0, 4, 1, 1'b0) : wave(c, 0, 4, 3, 1'b0));
            step();
        end
        clk_en = 1'b0;
        step();
        @(negedge clk);
        chk("R8 stop after shadow test", pwm_out, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule